// File: doc/BRIEF.md
# Address Trace Dictionary Compressor

This block shrinks a stream of bus addresses before they are written to on-chip trace storage. The reduction happens in two stages. The first stage is a run filter. It looks at each accepted address against the one before it, and it forwards only the addresses where the linear flow of accesses starts or stops. Addresses in the middle of a sequential run are dropped.

The second stage is a small content-addressable dictionary that holds recent forwarded addresses. When a forwarded address is already in the dictionary, the block emits the short slot index. Otherwise it emits the whole address as a literal and stores it in the next slot. Slots fill in ascending order and wrap round-robin once the last one is used.

A host tool that has the same dictionary rules can rebuild the address stream from the emitted codes. A synchronous clear input starts a new trace from an empty state.

Top module: `addr_trace_compressor`

## Requirements
- R1: After reset, and in the cycle that follows a cycle with `clear` high, `out_valid` is 0. A clear also discards the held beat, so the first beat accepted after a clear emits nothing.
- R2: A beat continues a run when `in_seq` is 1 and `in_addr` equals the previous accepted address plus `1 << in_size` bytes (`in_size` is log2 of the transfer size in bytes). A beat that continues a run and is followed by another continuing beat is never emitted.
- R3: A beat that does not continue a run is a run start. Every run start is emitted, including the first beat after reset or clear.
- R4: A continuing beat is emitted as a run end when the next accepted beat does not continue the run.
- R5: Each beat is held until the next beat is accepted (`in_valid` high with `clear` low). Its code then appears on the outputs in the cycle after that acceptance, with `out_valid` high for that one cycle. A beat with no successor stays held.
- R6: When an emitted address is not in the dictionary, `out_hit` is 0 and `out_code` carries the full address.
- R7: When an emitted address is in the dictionary, `out_hit` is 1 and `out_code` carries the slot index in bits [3:0], with every other bit 0.
- R8: Missed addresses are stored in slots 0, 1, 2, and so on. After slot 15, the next miss overwrites slot 0 and replacement continues in ascending order from there.
- R9: A miss and its insertion take effect together, so an address emitted twice in a row gives one literal followed by a hit.
- R10: A clear empties every slot and returns the fill position to slot 0. An address seen before the clear then misses, and the first miss after the clear lands in slot 0.
- R11: A cycle with `in_valid` low changes nothing and gives `out_valid` low in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clear | input | 1 | Synchronous clear of the held beat and the dictionary; takes priority over `in_valid` |
| in_valid | input | 1 | An address beat is presented |
| in_addr | input | 32 | Beat address |
| in_seq | input | 1 | The bus marks this beat as sequential to the previous one |
| in_size | input | 2 | log2 of the transfer size in bytes |
| out_valid | output | 1 | A code is presented this cycle |
| out_hit | output | 1 | 1: `out_code` is a slot index; 0: `out_code` is a literal address |
| out_code | output | 32 | Slot index (zero-extended) or full address |

## Verification
The compressor is driven with directed streams first:
- A run with a start, a middle beat, an idle cycle and an end tells dropped middle beats apart from emitted run boundaries.
- A bus-sequential beat whose address breaks the increment tells the `in_seq` flag apart from the address test.
- Repeated identical addresses separate literals from hits.
- Eighteen distinct addresses wrap the fill position, and the hits and misses that follow show which slots were overwritten.

Constrained random streams of runs with mixed sizes, broken runs, idle cycles and occasional clears, over a small address pool, then exercise hit, miss and replacement in many interleavings.

// File: rtl/atc_pkg.sv
package atc_pkg;

    localparam int unsigned ATC_ADDR_W = 32;
    localparam int unsigned ATC_DEPTH  = 16;
    localparam int unsigned ATC_SIZE_W = 2;

    // Kind of code carried on the output stream
    typedef enum logic {
        CODE_LITERAL = 1'b0,
        CODE_INDEX   = 1'b1
    } code_kind_e;

endpackage

// File: rtl/atc_run_filter.sv
module atc_run_filter
    import atc_pkg::*;
#(
    parameter int unsigned ADDR_W = ATC_ADDR_W,
    parameter int unsigned SIZE_W = ATC_SIZE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              in_valid,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic              in_seq,
    input  logic [SIZE_W-1:0] in_size,
    output logic              emit_valid,
    output logic [ADDR_W-1:0] emit_addr
);

    typedef struct packed {
        logic              held;   // a beat is waiting for its successor
        logic              start;  // the waiting beat opened a run
        logic [ADDR_W-1:0] addr;
    } flt_state_t;

    flt_state_t st_d, st_q;
    logic [ADDR_W-1:0] stride;
    logic              cont;

    always_comb begin
        st_d       = st_q;
        stride     = ADDR_W'(1) << in_size;
        cont       = in_seq && st_q.held && (in_addr == st_q.addr + stride);
        emit_valid = in_valid && !clear && st_q.held && (st_q.start || !cont);
        emit_addr  = st_q.addr;
        if (clear) begin
            st_d = '0;
        end else if (in_valid) begin
            st_d.held  = 1'b1;
            st_d.start = !cont;
            st_d.addr  = in_addr;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/atc_dict.sv
module atc_dict
    import atc_pkg::*;
#(
    parameter int unsigned ADDR_W = ATC_ADDR_W,
    parameter int unsigned DEPTH  = ATC_DEPTH,
    localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              look_valid,
    input  logic [ADDR_W-1:0] look_addr,
    output logic              hit,
    output logic [IDX_W-1:0]  hit_idx
);

    typedef struct packed {
        logic [DEPTH-1:0]             vld;
        logic [DEPTH-1:0][ADDR_W-1:0] tag;
        logic [IDX_W-1:0]             ptr;
    } dict_state_t;

    dict_state_t st_d, st_q;
    logic [DEPTH-1:0] match;

    // One comparator per slot
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        assign match[g] = st_q.vld[g] && (st_q.tag[g] == look_addr);
    end

    always_comb begin
        hit     = |match;
        hit_idx = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (match[i]) begin
                hit_idx = IDX_W'(i);
            end
        end

        st_d = st_q;
        if (clear) begin
            st_d.vld = '0;
            st_d.ptr = '0;
        end else if (look_valid && !hit) begin
            st_d.vld[st_q.ptr] = 1'b1;
            st_d.tag[st_q.ptr] = look_addr;
            st_d.ptr = (st_q.ptr == IDX_W'(DEPTH - 1)) ? '0 : st_q.ptr + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/addr_trace_compressor.sv
module addr_trace_compressor
    import atc_pkg::*;
#(
    parameter int unsigned ADDR_W = ATC_ADDR_W,
    parameter int unsigned DEPTH  = ATC_DEPTH,
    parameter int unsigned SIZE_W = ATC_SIZE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              in_valid,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic              in_seq,
    input  logic [SIZE_W-1:0] in_size,
    output logic              out_valid,
    output logic              out_hit,
    output logic [ADDR_W-1:0] out_code
);

    localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    typedef struct packed {
        logic              valid;
        code_kind_e        kind;
        logic [ADDR_W-1:0] code;
    } out_state_t;

    logic              emit_valid;
    logic [ADDR_W-1:0] emit_addr;
    logic              dict_hit;
    logic [IDX_W-1:0]  dict_idx;
    out_state_t        out_d, out_q;

    atc_run_filter #(
        .ADDR_W (ADDR_W),
        .SIZE_W (SIZE_W)
    ) u_filter (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (clear),
        .in_valid   (in_valid),
        .in_addr    (in_addr),
        .in_seq     (in_seq),
        .in_size    (in_size),
        .emit_valid (emit_valid),
        .emit_addr  (emit_addr)
    );

    atc_dict #(
        .ADDR_W (ADDR_W),
        .DEPTH  (DEPTH)
    ) u_dict (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (clear),
        .look_valid (emit_valid),
        .look_addr  (emit_addr),
        .hit        (dict_hit),
        .hit_idx    (dict_idx)
    );

    always_comb begin
        out_d.valid = emit_valid;
        out_d.kind  = dict_hit ? CODE_INDEX : CODE_LITERAL;
        out_d.code  = dict_hit ? ADDR_W'(dict_idx) : emit_addr;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign out_valid = out_q.valid;
    assign out_hit   = (out_q.kind == CODE_INDEX);
    assign out_code  = out_q.code;

endmodule

// File: rtl/atc_checker.sv
module atc_checker #(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned DEPTH  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              clear,
    input logic              in_valid,
    input logic              out_valid,
    input logic              out_hit,
    input logic [ADDR_W-1:0] out_code
);

    localparam int unsigned FILL_W = $clog2(DEPTH + 1);

    // Number of slots filled so far, counted from the literals seen on the outputs
    logic [FILL_W-1:0] fill_d, fill_q;

    always_comb begin
        fill_d = fill_q;
        if (clear) begin
            fill_d = '0;
        end else if (out_valid && !out_hit && fill_q != FILL_W'(DEPTH)) begin
            fill_d = fill_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fill_q <= '0;
        end else begin
            fill_q <= fill_d;
        end
    end

    // R11: an idle cycle yields no output next cycle
    a_r11_idle_silent: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R1: a clear yields no output next cycle
    a_r1_clear_silent: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> !out_valid);

    // R5: every output follows an accepted beat one cycle earlier
    a_r5_follows_accept: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid && !clear));

    // R7: a hit code is a small index
    a_r7_index_range: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_hit) |-> (out_code < ADDR_W'(DEPTH)));

    // R8 / R10: a hit refers to a slot that has already been filled since the last clear
    a_r8_hit_filled: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_hit) |-> (out_code < ADDR_W'(fill_q)));

    // R9: two back-to-back literals never carry the same address
    a_r9_no_repeat_literal: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_hit && $past(out_valid && !out_hit && !clear))
            |-> (out_code != $past(out_code)));

endmodule

bind addr_trace_compressor atc_checker #(
    .ADDR_W (ADDR_W),
    .DEPTH  (DEPTH)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (clear),
    .in_valid  (in_valid),
    .out_valid (out_valid),
    .out_hit   (out_hit),
    .out_code  (out_code)
);

// File: tb/addr_trace_compressor_bench.sv
module addr_trace_compressor_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NSLOT      = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clear = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_addr = '0;
    logic        in_seq = 1'b0;
    logic [1:0]  in_size = '0;
    logic        out_valid;
    logic        out_hit;
    logic [31:0] out_code;

    int n_checks = 0;
    int n_fail   = 0;

    // Reference state built from the requirements
    logic        m_held = 1'b0;
    logic        m_start = 1'b0;
    logic [31:0] m_addr = '0;
    logic [31:0] m_tag [NSLOT];
    logic        m_tv  [NSLOT];
    int          m_ptr = 0;
    logic        e_v, e_h;
    logic [31:0] e_c;

    addr_trace_compressor u_addr_trace_compressor (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (clear),
        .in_valid  (in_valid),
        .in_addr   (in_addr),
        .in_seq    (in_seq),
        .in_size   (in_size),
        .out_valid (out_valid),
        .out_hit   (out_hit),
        .out_code  (out_code)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic model_step(input logic v, input logic [31:0] a, input logic s,
                              input logic [1:0] sz, input logic c);
        logic cont;
        int   found;
        e_v = 1'b0; e_h = 1'b0; e_c = '0;
        if (c) begin
            m_held = 1'b0;
            for (int i = 0; i < NSLOT; i++) m_tv[i] = 1'b0;
            m_ptr = 0;
        end else if (v) begin
            cont = s && m_held && (a == m_addr + (32'd1 << sz));
            if (m_held && (m_start || !cont)) begin
                e_v = 1'b1;
                found = -1;
                for (int i = NSLOT - 1; i >= 0; i--)
                    if (m_tv[i] && m_tag[i] == m_addr) found = i;
                if (found >= 0) begin
                    e_h = 1'b1;
                    e_c = 32'(found);
                end else begin
                    e_c = m_addr;
                    m_tag[m_ptr] = m_addr;
                    m_tv[m_ptr] = 1'b1;
                    m_ptr = (m_ptr + 1) % NSLOT;
                end
            end
            m_held = 1'b1;
            m_start = !cont;
            m_addr = a;
        end
    endtask

    task automatic compare(input string tag, input logic v, input logic h, input logic [31:0] c);
        n_checks++;
        if (out_valid !== v || (v && (out_hit !== h || out_code !== c))) begin
            n_fail++;
            $display("FAIL %s: got v=%0b h=%0b code=%h, expected v=%0b h=%0b code=%h",
                     tag, out_valid, out_hit, out_code, v, h, c);
        end
    endtask

    // Drive one cycle, then compare outputs with the reference model
    task automatic step(input logic v, input logic [31:0] a, input logic s,
                        input logic [1:0] sz, input logic c, input string tag);
        @(negedge clk);
        in_valid = v; in_addr = a; in_seq = s; in_size = sz; clear = c;
        @(posedge clk);
        #1;
        model_step(v, a, s, sz, c);
        compare(tag, e_v, e_h, e_c);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got hung run, expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < NSLOT; i++) begin m_tv[i] = 1'b0; m_tag[i] = '0; end
        repeat (3) @(posedge clk);
        #1;
        compare("R1 reset state", 1'b0, 1'b0, '0);
        @(negedge clk);
        rst_n = 1'b1;

        // Run filter, literals and hits
        step(1, 32'h1000, 0, 2, 0, "R5 first beat held");
        compare("R5 first beat held", 0, 0, 0);
        step(1, 32'h1004, 1, 2, 0, "R3 run start");
        compare("R3 R6 run start literal", 1, 0, 32'h1000);
        step(1, 32'h1008, 1, 2, 0, "R2 middle beat");
        compare("R2 middle dropped", 0, 0, 0);
        step(0, 32'hdead, 1, 2, 0, "R11 idle");
        compare("R11 idle silent", 0, 0, 0);
        step(1, 32'h100c, 1, 0, 0, "R4 seq flag but wrong stride");
        compare("R4 run end literal", 1, 0, 32'h1008);
        step(1, 32'h1000, 0, 2, 0, "R3 start emitted");
        compare("R3 start of single-beat run", 1, 0, 32'h100c);
        step(1, 32'h1000, 0, 2, 0, "R7 hit");
        compare("R7 hit slot 0", 1, 1, 32'h0);
        step(1, 32'h1000, 0, 2, 0, "R9 repeat");
        compare("R9 repeated address hits", 1, 1, 32'h0);

        // Clear behaviour
        step(0, 0, 0, 0, 1, "R1 clear");
        compare("R1 clear silent", 0, 0, 0);
        step(1, 32'h1000, 0, 0, 0, "R1 held beat dropped");
        compare("R1 held beat discarded", 0, 0, 0);
        step(1, 32'h1000, 0, 0, 0, "R10 miss after clear");
        compare("R10 old address misses after clear", 1, 0, 32'h1000);
        step(1, 32'h1000, 0, 0, 0, "R10 slot 0 refilled");
        compare("R9 R10 literal then hit in slot 0", 1, 1, 32'h0);

        // Fill order and wrap
        step(0, 0, 0, 0, 1, "R8 clear");
        for (int k = 0; k < 18; k++)
            step(1, 32'h100 * (k + 1), 0, 2, 0, "R8 fill");
        compare("R8 seventeenth literal", 1, 0, 32'h1100);
        step(1, 32'h1100, 0, 2, 0, "R8 overwrite slot 1");
        compare("R8 literal into slot 1", 1, 0, 32'h1200);
        step(1, 32'h300, 0, 2, 0, "R8 wrap hit");
        compare("R8 wrapped address in slot 0", 1, 1, 32'h0);
        step(1, 32'h9999_0000, 0, 2, 0, "R8 untouched slot");
        compare("R8 slot 2 untouched", 1, 1, 32'h2);
        step(1, 32'h5, 0, 2, 0, "R8 miss");
        step(1, 32'h100, 0, 2, 0, "R8 miss");
        step(1, 32'h7, 0, 2, 0, "R8 overwritten");
        compare("R8 overwritten address misses", 1, 0, 32'h100);

        // Constrained random stream
        void'($urandom(32'd1234));
        begin
            logic [31:0] pool [8];
            logic [31:0] cur;
            logic [1:0]  sz;
            int          len;
            for (int i = 0; i < 8; i++) pool[i] = $urandom & 32'hffff_fff0;
            for (int n = 0; n < 800; n++) begin
                if ($urandom_range(99) == 0) step(0, 0, 0, 0, 1, "R10 random clear");
                cur = pool[$urandom_range(7)];
                sz  = 2'($urandom_range(2));
                step(1, cur, 0, sz, 0, "R3 random start");
                len = $urandom_range(5);
                for (int j = 0; j < len; j++) begin
                    if ($urandom_range(9) == 0) step(0, $urandom, 1, sz, 0, "R11 random idle");
                    if ($urandom_range(14) == 0) cur = cur + 32'h40;
                    else cur = cur + (32'd1 << sz);
                    step(1, cur, 1, sz, 0, "R2 R4 random run");
                end
            end
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule